// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment entries. Each entry pairs an ESID word (the segment's effective-address tag plus a valid bit) with a VSID word (the virtual segment ID and a two-bit segment-size field). An associative lookup takes a 64-bit effective address and finds the entry covering it. Segments of 256 MB and of 1 TB can sit in the table together, and each entry is matched at the granularity its own size field selects.

Software-visible operations arrive as single-cycle request pulses. A store writes one slot after checking the slot number and the size encoding. Read-back returns either word of a slot. Invalidate-one clears the valid bit of the entry that a given address hits. Invalidate-all clears every entry except slot 0. A rejected store or an out-of-range read-back produces a one-cycle error pulse. Lookup and read-back results appear in registers one cycle after the request. The entry count must be a power of two, from 2 to 2048.

Top module: `slb_array`

## Requirements
- R1: After reset every entry is zero, and therefore invalid. All output registers are zero, every read-back returns zero, and any lookup misses. `err_q` only pulses in the cycle after a store or read-back request.
- R2: A 256 MB entry (VSID bits [63:62] = 2'b00) hits when its stored ESID bits [63:28] equal EA[63:28] and its bit 27 (valid) is set. The cycle after `lk_valid`, `lk_rsp_q` pulses and `lk_hit_q`, `lk_idx_q` and `lk_vsid_q` (the full VSID word) hold the result. On a miss, `lk_idx_q` and `lk_vsid_q` are zero.
- R3: A 1 TB entry (VSID bits [63:62] = 2'b01) hits when its stored bits [63:40] equal EA[63:40], its stored bits [39:28] are zero, and it is valid. EA[39:0] are then ignored.
- R4: An entry never hits through the other size's key. A 1 TB entry with nonzero ESID bits [39:28] never hits. A 256 MB entry misses when EA[39:28] differ from its stored bits, even if EA[63:40] match.
- R5: When several entries hit, the lowest-numbered one is reported.
- R6: A store takes its slot from `st_addr[11:0]`. If any bit of that field at or above log2(entry count) is set, the store is rejected: `err_q` pulses the next cycle and no entry changes.
- R7: A store whose `st_vsid[63:62]` is 2'b10 or 2'b11 is rejected with an error pulse, and no entry changes.
- R8: When 1 TB support is configured off, a store with size 2'b01 is rejected with an error pulse. 256 MB stores are still accepted.
- R9: An accepted store keeps only bits [63:27] of `st_addr` as the ESID word; bits [26:0], including the slot field, read back as zero. The VSID word is kept whole.
- R10: Read-back with `rd_sel`=0 returns the ESID word and with `rd_sel`=1 the VSID word of slot `rd_slot`, in `rd_data_q` with `rd_rsp_q` one cycle later. A slot at or above the entry count gives an `err_q` pulse and no `rd_rsp_q`.
- R11: Invalidate-all clears bit 27 of the ESID word in every slot except slot 0. Slot 0 and all other bits are left as they were.
- R12: Invalidate-one clears the valid bit of the lowest-numbered entry hit by `inv_one_ea`, with the same matching as lookup. A miss changes nothing.
- R13: Invalidate-all takes priority over invalidate-one, which takes priority over a store. A store in a cycle that has either invalidate request is dropped. A lookup or read-back sees the table as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 64 | Effective address to look up |
| inv_one_valid | input | 1 | Invalidate-one request |
| inv_one_ea | input | 64 | Address whose hit entry is invalidated |
| inv_all | input | 1 | Invalidate all entries except slot 0 |
| st_valid | input | 1 | Store request |
| st_addr | input | 64 | ESID, valid bit [27] and slot number [11:0] |
| st_vsid | input | 64 | VSID word, size field [63:62] |
| rd_valid | input | 1 | Read-back request |
| rd_sel | input | 1 | 0 selects the ESID word, 1 the VSID word |
| rd_slot | input | 12 | Slot to read |
| lk_rsp_q | output | 1 | Lookup result valid |
| lk_hit_q | output | 1 | Lookup hit |
| lk_idx_q | output | log2(NUM_ENTRIES) | Index of the winning entry |
| lk_vsid_q | output | 64 | VSID word of the winning entry |
| rd_rsp_q | output | 1 | Read-back data valid |
| rd_data_q | output | 64 | Read-back data |
| err_q | output | 1 | Rejected store or bad read-back slot |

## Verification
The hardest case to reach from the ports is an entry that looks right for one segment size but is marked with the other. Examples are a 1 TB entry whose ESID has nonzero bits between 28 and 39, and a 256 MB entry whose upper 24 bits match an address that differs only in bits 28 to 39. The bench stores exactly these entries, then looks up both the address that would match under the wrong size and the one that matches under the right size. Concurrency cases come from driving a store in the same cycle as a lookup, as invalidate-one and as invalidate-all, and then reading the affected slots back. A second instance with 1 TB support off covers the configuration-dependent rejection.

// File: rtl/slb_pkg.sv
package slb_pkg;

  localparam int EA_W      = 64;
  localparam int SLOT_W    = 12;
  localparam int SEG256_LO = 28;
  localparam int SEG1T_LO  = 40;
  localparam int VLD_POS   = 27;
  localparam int SZ_HI     = 63;
  localparam int SZ_LO     = 62;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_1T   = 2'b01,
    SZ_RSV2 = 2'b10,
    SZ_RSV3 = 2'b11
  } seg_sz_e;

  typedef struct packed {
    logic [EA_W-1:0] esid;
    logic [EA_W-1:0] vsid;
  } slb_ent_t;

  // ESID word keeps the tag and the valid bit only
  localparam logic [EA_W-1:0] ESID_KEEP  = {{(EA_W-VLD_POS){1'b1}}, {VLD_POS{1'b0}}};
  localparam logic [EA_W-1:0] MASK_256M  = {{(EA_W-SEG256_LO){1'b1}}, {SEG256_LO{1'b0}}};
  localparam logic [EA_W-1:0] MASK_1T    = {{(EA_W-SEG1T_LO){1'b1}}, {SEG1T_LO{1'b0}}};
  localparam logic [EA_W-1:0] VLD_ONE    = {{(EA_W-VLD_POS-1){1'b0}}, 1'b1, {VLD_POS{1'b0}}};

  function automatic logic [EA_W-1:0] key_256m(input logic [EA_W-1:0] ea);
    return (ea & MASK_256M) | VLD_ONE;
  endfunction

  function automatic logic [EA_W-1:0] key_1t(input logic [EA_W-1:0] ea);
    return (ea & MASK_1T) | VLD_ONE;
  endfunction

endpackage

// File: rtl/slb_key_match.sv
module slb_key_match
  import slb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [EA_W-1:0]      ea,
  input  slb_ent_t [N-1:0]     ents,
  output logic [N-1:0]         hit
);

  logic [EA_W-1:0] k256;
  logic [EA_W-1:0] k1t;

  assign k256 = key_256m(ea);
  assign k1t  = key_1t(ea);

  for (genvar g = 0; g < N; g++) begin : g_ent
    seg_sz_e sz;
    logic    m256;
    logic    m1t;
    assign sz   = seg_sz_e'(ents[g].vsid[SZ_HI:SZ_LO]);
    // keys carry the valid bit, so invalid entries can never compare equal
    assign m256 = (ents[g].esid == k256) && (sz == SZ_256M);
    assign m1t  = (ents[g].esid == k1t)  && (sz == SZ_1T);
    assign hit[g] = m256 | m1t;
  end

endmodule

// File: rtl/slb_first_hit.sv
module slb_first_hit #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/slb_store_check.sv
module slb_store_check
  import slb_pkg::*;
#(
  parameter int N         = 16,
  parameter int IDX_W     = 4,
  parameter bit ONE_TB_EN = 1'b1
) (
  input  logic [EA_W-1:0]  st_addr,
  input  logic [EA_W-1:0]  st_vsid,
  output logic             ok,
  output logic [IDX_W-1:0] slot,
  output logic [EA_W-1:0]  esid_word
);

  logic [SLOT_W-1:0] field;
  logic              slot_ok;
  logic              size_ok;
  seg_sz_e           sz;

  assign field     = st_addr[SLOT_W-1:0];
  assign slot      = field[IDX_W-1:0];
  assign slot_ok   = (field[SLOT_W-1:IDX_W] == '0);
  assign sz        = seg_sz_e'(st_vsid[SZ_HI:SZ_LO]);
  assign size_ok   = (sz == SZ_256M) || ((sz == SZ_1T) && ONE_TB_EN);
  assign ok        = slot_ok && size_ok;
  assign esid_word = st_addr & ESID_KEEP;

endmodule

// File: rtl/slb_entry_array.sv
module slb_entry_array
  import slb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             inv_one_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [EA_W-1:0]  wr_esid,
  input  logic [EA_W-1:0]  wr_vsid,
  output slb_ent_t [N-1:0] ents
);

  slb_ent_t [N-1:0] ent_q;
  slb_ent_t [N-1:0] ent_d;
  logic     [N-1:0] ent_en;

  always_comb begin
    ent_d  = ent_q;
    ent_en = '0;
    if (inv_all) begin
      for (int i = 1; i < N; i++) begin
        ent_d[i].esid[VLD_POS] = 1'b0;
        ent_en[i]              = 1'b1;
      end
    end else if (inv_one_en) begin
      ent_d[inv_idx].esid[VLD_POS] = 1'b0;
      ent_en[inv_idx]              = 1'b1;
    end else if (wr_en) begin
      ent_d[wr_idx].esid = wr_esid;
      ent_d[wr_idx].vsid = wr_vsid;
      ent_en[wr_idx]     = 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (ent_en[g]) begin
        ent_q[g] <= ent_d[g];
      end
    end
  end

  assign ents = ent_q;

endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  parameter  bit ONE_TB_EN   = 1'b1,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [63:0]      lk_ea,
  input  logic             inv_one_valid,
  input  logic [63:0]      inv_one_ea,
  input  logic             inv_all,
  input  logic             st_valid,
  input  logic [63:0]      st_addr,
  input  logic [63:0]      st_vsid,
  input  logic             rd_valid,
  input  logic             rd_sel,
  input  logic [11:0]      rd_slot,
  output logic             lk_rsp_q,
  output logic             lk_hit_q,
  output logic [IDX_W-1:0] lk_idx_q,
  output logic [63:0]      lk_vsid_q,
  output logic             rd_rsp_q,
  output logic [63:0]      rd_data_q,
  output logic             err_q
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  slb_ent_t [NUM_ENTRIES-1:0] ents;
  logic     [NUM_ENTRIES-1:0] ent_vld;
  logic     [NUM_ENTRIES-1:0] lk_hitvec;
  logic     [NUM_ENTRIES-1:0] inv_hitvec;
  logic                       lk_found;
  logic     [IDX_W-1:0]       lk_idx;
  logic                       inv_found;
  logic     [IDX_W-1:0]       inv_idx;
  logic                       st_ok;
  logic     [IDX_W-1:0]       st_slot;
  logic     [EA_W-1:0]        st_esid;
  logic                       wr_en;
  logic                       inv_one_en;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
    assign ent_vld[g] = ents[g].esid[VLD_POS];
  end

  slb_key_match #(.N(NUM_ENTRIES)) u_lk_match (
    .ea   (lk_ea),
    .ents (ents),
    .hit  (lk_hitvec)
  );

  slb_key_match #(.N(NUM_ENTRIES)) u_inv_match (
    .ea   (inv_one_ea),
    .ents (ents),
    .hit  (inv_hitvec)
  );

  slb_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .vec   (lk_hitvec),
    .found (lk_found),
    .idx   (lk_idx)
  );

  slb_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_inv_pick (
    .vec   (inv_hitvec),
    .found (inv_found),
    .idx   (inv_idx)
  );

  slb_store_check #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .ONE_TB_EN(ONE_TB_EN)) u_st_chk (
    .st_addr   (st_addr),
    .st_vsid   (st_vsid),
    .ok        (st_ok),
    .slot      (st_slot),
    .esid_word (st_esid)
  );

  assign inv_one_en = inv_one_valid && inv_found && !inv_all;
  assign wr_en      = st_valid && st_ok && !inv_all && !inv_one_valid;

  slb_entry_array #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_entries (
    .clk        (clk),
    .rst_n      (srst_n),
    .inv_all    (inv_all),
    .inv_one_en (inv_one_en),
    .inv_idx    (inv_idx),
    .wr_en      (wr_en),
    .wr_idx     (st_slot),
    .wr_esid    (st_esid),
    .wr_vsid    (st_vsid),
    .ents       (ents)
  );

  // read-back path
  logic             rd_bad;
  logic [IDX_W-1:0] rd_idx;
  logic [63:0]      rd_word;
  logic             rd_ok;

  assign rd_bad  = (rd_slot[SLOT_W-1:IDX_W] != '0);
  assign rd_idx  = rd_slot[IDX_W-1:0];
  assign rd_word = rd_sel ? ents[rd_idx].vsid : ents[rd_idx].esid;
  assign rd_ok   = rd_valid && !rd_bad;

  // response next-state
  logic             lk_hit_d;
  logic [IDX_W-1:0] lk_idx_d;
  logic [63:0]      lk_vsid_d;
  logic             err_d;

  always_comb begin
    lk_hit_d  = lk_found;
    lk_idx_d  = lk_found ? lk_idx : '0;
    lk_vsid_d = lk_found ? ents[lk_idx].vsid : '0;
    err_d     = (st_valid && !st_ok) || (rd_valid && rd_bad);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lk_rsp_q  <= 1'b0;
      lk_hit_q  <= 1'b0;
      lk_idx_q  <= '0;
      lk_vsid_q <= '0;
      rd_rsp_q  <= 1'b0;
      rd_data_q <= '0;
      err_q     <= 1'b0;
    end else begin
      lk_rsp_q <= lk_valid;
      rd_rsp_q <= rd_ok;
      err_q    <= err_d;
      if (lk_valid) begin
        lk_hit_q  <= lk_hit_d;
        lk_idx_q  <= lk_idx_d;
        lk_vsid_q <= lk_vsid_d;
      end
      if (rd_ok) begin
        rd_data_q <= rd_word;
      end
    end
  end

endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             srst_n,
  input logic             lk_valid,
  input logic             inv_all,
  input logic             inv_one_valid,
  input logic             st_valid,
  input logic             st_ok,
  input logic             rd_valid,
  input logic [11:0]      rd_slot,
  input logic [N-1:0]     lk_hitvec,
  input logic [N-1:0]     ent_vld,
  input logic             lk_rsp_q,
  input logic             lk_hit_q,
  input logic [IDX_W-1:0] lk_idx_q,
  input logic             rd_rsp_q,
  input logic             err_q
);

  assert_err_has_cause_R1: assert property (@(posedge clk) disable iff (!srst_n)
    err_q |-> $past(st_valid || rd_valid));

  assert_lookup_rsp_R2: assert property (@(posedge clk) disable iff (!srst_n)
    lk_valid |=> lk_rsp_q);

  assert_lookup_hit_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (lk_valid && (lk_hitvec != '0)) |=> lk_hit_q);

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (lk_valid && lk_hitvec[0]) |=> (lk_idx_q == '0));

  assert_bad_store_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (st_valid && !st_ok && !inv_all && !inv_one_valid) |=> (err_q && $stable(ent_vld)));

  assert_bad_read_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_valid && (rd_slot[11:IDX_W] != '0)) |=> (err_q && !rd_rsp_q));

  assert_inv_all_R11: assert property (@(posedge clk) disable iff (!srst_n)
    inv_all |=> ((ent_vld[N-1:1] == '0) && (ent_vld[0] == $past(ent_vld[0]))));

endmodule

bind slb_array slb_array_chk #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .srst_n        (srst_n),
  .lk_valid      (lk_valid),
  .inv_all       (inv_all),
  .inv_one_valid (inv_one_valid),
  .st_valid      (st_valid),
  .st_ok         (st_ok),
  .rd_valid      (rd_valid),
  .rd_slot       (rd_slot),
  .lk_hitvec     (lk_hitvec),
  .ent_vld       (ent_vld),
  .lk_rsp_q      (lk_rsp_q),
  .lk_hit_q      (lk_hit_q),
  .lk_idx_q      (lk_idx_q),
  .rd_rsp_q      (rd_rsp_q),
  .err_q         (err_q)
);

// File: tb/slb_array_test.sv
`timescale 1ns/1ps
module slb_array_test;

  localparam logic [63:0] V = 64'h0000_0000_0800_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, inv_one_valid, inv_all, st_valid, rd_valid, rd_sel;
  logic [63:0] lk_ea, inv_one_ea, st_addr, st_vsid;
  logic [11:0] rd_slot;
  logic        lk_rsp_q, lk_hit_q, rd_rsp_q, err_q;
  logic [3:0]  lk_idx_q;
  logic [63:0] lk_vsid_q, rd_data_q;

  // second instance: 4 entries, 1 TB segments disabled
  logic        b_lk_valid, b_st_valid, b_rd_valid;
  logic [63:0] b_lk_ea, b_st_addr, b_st_vsid;
  logic [11:0] b_rd_slot;
  logic        b_lk_rsp_q, b_lk_hit_q, b_rd_rsp_q, b_err_q;
  logic [1:0]  b_lk_idx_q;
  logic [63:0] b_lk_vsid_q, b_rd_data_q;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  slb_array #(.NUM_ENTRIES(16), .ONE_TB_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ea(lk_ea),
    .inv_one_valid(inv_one_valid), .inv_one_ea(inv_one_ea), .inv_all(inv_all),
    .st_valid(st_valid), .st_addr(st_addr), .st_vsid(st_vsid),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_slot(rd_slot),
    .lk_rsp_q(lk_rsp_q), .lk_hit_q(lk_hit_q), .lk_idx_q(lk_idx_q),
    .lk_vsid_q(lk_vsid_q), .rd_rsp_q(rd_rsp_q), .rd_data_q(rd_data_q), .err_q(err_q)
  );

  slb_array #(.NUM_ENTRIES(4), .ONE_TB_EN(1'b0)) uut_n1t (
    .clk(clk), .rst_n(rst_n), .lk_valid(b_lk_valid), .lk_ea(b_lk_ea),
    .inv_one_valid(1'b0), .inv_one_ea(64'h0), .inv_all(1'b0),
    .st_valid(b_st_valid), .st_addr(b_st_addr), .st_vsid(b_st_vsid),
    .rd_valid(b_rd_valid), .rd_sel(1'b0), .rd_slot(b_rd_slot),
    .lk_rsp_q(b_lk_rsp_q), .lk_hit_q(b_lk_hit_q), .lk_idx_q(b_lk_idx_q),
    .lk_vsid_q(b_lk_vsid_q), .rd_rsp_q(b_rd_rsp_q), .rd_data_q(b_rd_data_q), .err_q(b_err_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [63:0] a, input logic [63:0] v);
    st_valid = 1'b1; st_addr = a; st_vsid = v;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [63:0] ea);
    lk_valid = 1'b1; lk_ea = ea;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_read(input logic sel, input logic [11:0] slot);
    rd_valid = 1'b1; rd_sel = sel; rd_slot = slot;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [63:0] ea,
                            input logic [3:0] idx, input logic [63:0] vsid);
    do_lookup(ea);
    chk({tag, " rsp"}, 64'(lk_rsp_q), 64'd1);
    chk({tag, " hit"}, 64'(lk_hit_q), 64'd1);
    chk({tag, " idx"}, 64'(lk_idx_q), 64'(idx));
    chk({tag, " vsid"}, lk_vsid_q, vsid);
  endtask

  task automatic expect_miss(input string tag, input logic [63:0] ea);
    do_lookup(ea);
    chk({tag, " miss"}, 64'(lk_hit_q), 64'd0);
    chk({tag, " miss vsid"}, lk_vsid_q, 64'd0);
  endtask

  task automatic expect_word(input string tag, input logic sel, input logic [11:0] slot,
                             input logic [63:0] exp);
    do_read(sel, slot);
    chk({tag, " rd_rsp"}, 64'(rd_rsp_q), 64'd1);
    chk({tag, " rd_data"}, rd_data_q, exp);
  endtask

  task automatic t_reset;
    chk("R1 err after reset", 64'(err_q), 64'd0);
    chk("R1 lk_rsp after reset", 64'(lk_rsp_q), 64'd0);
    chk("R1 lk_vsid after reset", lk_vsid_q, 64'd0);
    for (int s = 0; s < 16; s++) begin
      expect_word("R1 esid zero", 1'b0, 12'(s), 64'd0);
    end
    expect_word("R1 vsid zero", 1'b1, 12'd15, 64'd0);
    expect_miss("R1 empty", 64'h0);
    chk("R1 no err", 64'(err_q), 64'd0);
  endtask

  task automatic t_256m;
    do_store(64'h1234_5678_9000_0000 | V | 64'h0012_3003, 64'h0000_00AB_CDEF_0100);
    chk("R2 store no err", 64'(err_q), 64'd0);
    expect_hit("R2 256M hit", 64'h1234_5678_9ABC_DEF0, 4'd3, 64'h0000_00AB_CDEF_0100);
    expect_miss("R2 256M neighbour", 64'h1234_5678_A000_0000);
    expect_word("R9 esid masked", 1'b0, 12'd3, 64'h1234_5678_9800_0000);
  endtask

  task automatic t_1t;
    do_store(64'hABCD_EF00_0000_0000 | V | 64'd5, 64'h4000_0012_3456_7000);
    chk("R3 store no err", 64'(err_q), 64'd0);
    expect_hit("R3 1T hit", 64'hABCD_EF12_3456_789A, 4'd5, 64'h4000_0012_3456_7000);
    expect_miss("R3 1T other", 64'hABCD_EE00_0000_0000);
  endtask

  task automatic t_size_mismatch;
    do_store(64'hCCCC_CC12_3000_0000 | V | 64'd6, 64'h4000_0000_0000_0006);
    expect_miss("R4 1T with low bits", 64'hCCCC_CC12_3000_0000);
    do_store(64'h1111_1100_0000_0000 | V | 64'd7, 64'h0000_0000_0000_0007);
    expect_miss("R4 256M via 1T key", 64'h1111_1100_5000_0000);
    expect_hit("R4 256M exact", 64'h1111_1100_0FFF_FFFF, 4'd7, 64'h7);
  endtask

  task automatic t_priority_lowest;
    do_store(64'h7777_7777_7000_0000 | V | 64'd9, 64'h9);
    do_store(64'h7777_7777_7000_0000 | V | 64'd2, 64'h2);
    expect_hit("R5 lowest index", 64'h7777_7777_7000_0001, 4'd2, 64'h2);
  endtask

  task automatic t_bad_slot;
    do_store(64'h2222_2222_2000_0000 | V | 64'h010, 64'h0);
    chk("R6 slot 16 err", 64'(err_q), 64'd1);
    expect_word("R6 slot 0 untouched", 1'b0, 12'd0, 64'd0);
    expect_miss("R6 no entry", 64'h2222_2222_2000_0000);
    do_store(64'h2222_2222_2000_0000 | V | 64'h800, 64'h0);
    chk("R6 slot 0x800 err", 64'(err_q), 64'd1);
    @(negedge clk);
    chk("R6 err is a pulse", 64'(err_q), 64'd0);
  endtask

  task automatic t_bad_size;
    do_store(64'h3333_3333_3000_0000 | V | 64'd8, 64'h8000_0000_0000_0000);
    chk("R7 size 10 err", 64'(err_q), 64'd1);
    do_store(64'h3333_3333_3000_0000 | V | 64'd8, 64'hC000_0000_0000_0000);
    chk("R7 size 11 err", 64'(err_q), 64'd1);
    expect_word("R7 slot 8 untouched", 1'b0, 12'd8, 64'd0);
    expect_miss("R7 no entry", 64'h3333_3333_3000_0000);
  endtask

  task automatic t_no_1t;
    b_st_valid = 1'b1; b_st_addr = 64'hABCD_EF00_0000_0000 | V | 64'd1;
    b_st_vsid = 64'h4000_0012_3456_7000;
    @(negedge clk);
    b_st_valid = 1'b0;
    chk("R8 1T rejected", 64'(b_err_q), 64'd1);
    b_rd_valid = 1'b1; b_rd_slot = 12'd1;
    @(negedge clk);
    b_rd_valid = 1'b0;
    chk("R8 slot 1 untouched", b_rd_data_q, 64'd0);
    b_st_valid = 1'b1; b_st_addr = 64'h1234_5678_9000_0000 | V | 64'd2;
    b_st_vsid = 64'h0000_00AB_CDEF_0100;
    @(negedge clk);
    b_st_valid = 1'b0;
    chk("R8 256M accepted", 64'(b_err_q), 64'd0);
    b_lk_valid = 1'b1; b_lk_ea = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    b_lk_valid = 1'b0;
    chk("R8 256M hit", 64'(b_lk_hit_q), 64'd1);
    chk("R8 256M idx", 64'(b_lk_idx_q), 64'd2);
  endtask

  task automatic t_readback;
    expect_word("R10 vsid word", 1'b1, 12'd5, 64'h4000_0012_3456_7000);
    expect_word("R10 esid word", 1'b0, 12'd5, 64'hABCD_EF00_0000_0000 | V);
    do_read(1'b0, 12'd16);
    chk("R10 bad slot err", 64'(err_q), 64'd1);
    chk("R10 bad slot no rsp", 64'(rd_rsp_q), 64'd0);
  endtask

  task automatic t_inv_one;
    inv_one_valid = 1'b1; inv_one_ea = 64'h7777_7777_7000_0000;
    @(negedge clk);
    inv_one_valid = 1'b0;
    expect_hit("R12 next entry wins", 64'h7777_7777_7000_0000, 4'd9, 64'h9);
    expect_word("R12 valid cleared", 1'b0, 12'd2, 64'h7777_7777_7000_0000);
    inv_one_valid = 1'b1; inv_one_ea = 64'h5555_5555_5000_0000;
    @(negedge clk);
    inv_one_valid = 1'b0;
    expect_hit("R12 miss changes nothing", 64'h1234_5678_9000_0000, 4'd3, 64'h0000_00AB_CDEF_0100);
    expect_hit("R12 miss keeps 9", 64'h7777_7777_7000_0000, 4'd9, 64'h9);
  endtask

  task automatic t_concurrency;
    // store alongside a lookup of the same segment
    lk_valid = 1'b1; lk_ea = 64'h4444_4444_4000_0000;
    st_valid = 1'b1; st_addr = 64'h4444_4444_4000_0000 | V | 64'd10; st_vsid = 64'hA;
    @(negedge clk);
    lk_valid = 1'b0; st_valid = 1'b0;
    chk("R13 lookup sees old table", 64'(lk_hit_q), 64'd0);
    expect_hit("R13 store landed", 64'h4444_4444_4000_0000, 4'd10, 64'hA);
    // store alongside an invalidate-one (miss) is dropped
    inv_one_valid = 1'b1; inv_one_ea = 64'h5555_5555_5000_0000;
    st_valid = 1'b1; st_addr = 64'h4545_4545_4000_0000 | V | 64'd11; st_vsid = 64'hB;
    @(negedge clk);
    inv_one_valid = 1'b0; st_valid = 1'b0;
    expect_word("R13 store dropped by inv_one", 1'b0, 12'd11, 64'd0);
  endtask

  task automatic t_inv_all;
    do_store(64'h6666_6666_6000_0000 | V, 64'h0);
    inv_all = 1'b1;
    st_valid = 1'b1; st_addr = 64'h9999_9999_9000_0000 | V | 64'd12; st_vsid = 64'hC;
    @(negedge clk);
    inv_all = 1'b0; st_valid = 1'b0;
    expect_hit("R11 slot 0 kept", 64'h6666_6666_6000_0000, 4'd0, 64'h0);
    expect_miss("R11 slot 3 cleared", 64'h1234_5678_9000_0000);
    expect_miss("R11 slot 5 cleared", 64'hABCD_EF00_0000_0000);
    expect_word("R11 esid bits kept", 1'b0, 12'd3, 64'h1234_5678_9000_0000);
    expect_word("R11 vsid kept", 1'b1, 12'd3, 64'h0000_00AB_CDEF_0100);
    expect_word("R13 store dropped by inv_all", 1'b0, 12'd12, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; inv_one_valid = 1'b0; inv_all = 1'b0; st_valid = 1'b0;
    rd_valid = 1'b0; rd_sel = 1'b0; rd_slot = '0;
    lk_ea = '0; inv_one_ea = '0; st_addr = '0; st_vsid = '0;
    b_lk_valid = 1'b0; b_st_valid = 1'b0; b_rd_valid = 1'b0;
    b_lk_ea = '0; b_st_addr = '0; b_st_vsid = '0; b_rd_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_256m();
    t_1t();
    t_size_mismatch();
    t_priority_lowest();
    t_bad_slot();
    t_bad_size();
    t_no_1t();
    t_readback();
    t_inv_one();
    t_concurrency();
    t_inv_all();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule